// File: doc/BRIEF.md
# MMU Fault Status and TSB Pointer Unit

This block sits beside an address translator and holds the registers a software refill handler reads after a translation fault. When the translator reports a fault, the block captures a packed fault status word and the faulting address. When a lookup misses, the translator loads the tag-access register with the page number and context of the failed access.

The block also computes, combinationally, two translation-storage-buffer (TSB) pointers, one for each page-size class. It uses the tag-access value, a TSB base register and a config register. The base and config pair comes from the zero-context set or the nonzero-context set, picked by the context held in tag-access.

Software reaches all registers through a simple request port with 8-bit byte offsets. A read returns its data on the following cycle.

Top module: `mmufsr_top`

## Requirements
- R1: After reset every register reads as zero and `rdValid` stays low until a read request is made.
- R2: A fault record sets fault-status bits 1:0 to 2'b11 if fault-status bit 0 was already 1, and to 2'b01 otherwise.
- R3: A fault record rewrites the whole fault-status word as follows: bit 2 = write flag, bits 5:4 = context type, bit 6 = side-effect flag, bits 13:7 = fault type, bits 23:16 = access space identifier, and all other bits above bit 1 are zero. The word reads at offset 0x18.
- R4: A fault record captures the 64-bit fault address, which reads at offset 0x20.
- R5: A tag load sets tag-access to {VA[63:13], ctx[12:0]}. A software write at offset 0x30 stores the raw 64-bit value. A tag load wins over a write in the same cycle. Offset 0x30 reads the raw value.
- R6: Offset 0x00 reads {3'b0, tag[12:0], 6'b0, tag[63:22]}, placing the context at bits 60:48.
- R7: Software may write the fault status at offset 0x18. A fault record in the same cycle wins, and its overwrite test uses the value held before that cycle.
- R8: A read request gives `rdValid` high exactly one cycle later, carrying the value the register held in the request cycle. A write request never raises `rdValid`. Unmapped offsets read as zero. Writes to offsets 0x00, 0x20, 0x70, 0x78 and to unmapped offsets change nothing.
- R9: The TSB pointers use the zero-context base and config (0x40/0x48/0x50) when tag-access bits 12:0 are zero, and the nonzero-context set (0x58/0x60/0x68) otherwise.
- R10: The pointer for class k (read at 0x70 for k=0 and 0x78 for k=1) is built from three parts ORed together: the base bits 63:13, bits 63:13 of the pointer, and the tag-access value shifted right by 9 + 3*pgc and masked to bits (12 + size) down to 4. Here size is base bits 3:0.
- R11: For class 1 only, when base bit 12 (split) is set, pointer bit (13 + size) is also set. Class 0 ignores the split bit.
- R12: The page code pgc is config bits 2:0 for class 0 and config bits 10:8 for class 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | One-cycle fault record strobe |
| faultWrite | input | 1 | Faulting access was a store |
| faultCtxType | input | 2 | Context type of the faulting access |
| faultSideEffect | input | 1 | Side-effect flag of the faulting access |
| faultType | input | 7 | Fault type code |
| faultAsi | input | 8 | Access space identifier |
| faultAddr | input | 64 | Faulting virtual address |
| tagLoad | input | 1 | Load tag-access from translator |
| tagVpn | input | 51 | Virtual address bits 63:13 |
| tagCtx | input | 13 | Context number |
| regReq | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset |
| regWData | input | 64 | Write data |
| rdValid | output | 1 | Read data valid |
| rdData | output | 64 | Read data |

## Verification
Fault records, tag loads and register writes each take effect at the first clock edge. A read issued in the cycle after one of them returns the new value at the edge after that, so every observable result falls two edges after its stimulus. The TSB pointers are combinational from the registers, so a pointer read shows a change one cycle after the write that caused it. The bench drives every input at the falling edge, advances a behavioural model at the same point, and compares `rdValid` and `rdData` against the model at the next falling edge on every cycle.

// File: rtl/mmufsr_pkg.sv
package mmufsr_pkg;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 8;
  localparam int CTX_W  = 13;
  localparam int VPN_W  = DATA_W - CTX_W;
  localparam int FT_W   = 7;
  localparam int ASI_W  = 8;
  localparam int CT_W   = 2;
  localparam int SIZE_W = 4;
  localparam int PGC_W  = 3;
  localparam int N_CLASS = 2;

  localparam int FSR_WR_BIT = 2;
  localparam int FSR_CT_LSB = 4;
  localparam int FSR_SE_BIT = 6;
  localparam int FSR_FT_LSB = 7;
  localparam int FSR_ASI_LSB = 16;

  localparam logic [ADDR_W-1:0] OFS_TAGVIEW = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_FSR     = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_FAR     = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_TAG     = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ZBASE0  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_ZBASE1  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_ZCFG    = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_NBASE0  = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_NBASE1  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_NCFG    = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_PTR0    = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_PTR1    = 8'h78;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_TAGVIEW, SEL_FSR, SEL_FAR, SEL_TAG,
    SEL_ZBASE0, SEL_ZBASE1, SEL_ZCFG, SEL_NBASE0, SEL_NBASE1, SEL_NCFG,
    SEL_PTR0, SEL_PTR1
  } rdSel_e;

  typedef struct packed {
    logic               wrFsr;
    logic               wrTag;
    logic [N_CLASS-1:0] wrZeroBase;
    logic               wrZeroCfg;
    logic [N_CLASS-1:0] wrNzBase;
    logic               wrNzCfg;
    logic               rdEn;
    rdSel_e             rdSel;
  } strobe_t;
endpackage

// File: rtl/mmufsr_ctrl.sv
module mmufsr_ctrl
  import mmufsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regReq,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb,
  output logic              rdValid
);
  logic isRd, isWr;

  assign isRd = regReq && !regWrite;
  assign isWr = regReq && regWrite;

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    strb.rdEn  = isRd;
    if (isWr) begin
      case (regAddr)
        OFS_FSR:    strb.wrFsr = 1'b1;
        OFS_TAG:    strb.wrTag = 1'b1;
        OFS_ZBASE0: strb.wrZeroBase[0] = 1'b1;
        OFS_ZBASE1: strb.wrZeroBase[1] = 1'b1;
        OFS_ZCFG:   strb.wrZeroCfg = 1'b1;
        OFS_NBASE0: strb.wrNzBase[0] = 1'b1;
        OFS_NBASE1: strb.wrNzBase[1] = 1'b1;
        OFS_NCFG:   strb.wrNzCfg = 1'b1;
        default:    ;
      endcase
    end
    if (isRd) begin
      case (regAddr)
        OFS_TAGVIEW: strb.rdSel = SEL_TAGVIEW;
        OFS_FSR:     strb.rdSel = SEL_FSR;
        OFS_FAR:     strb.rdSel = SEL_FAR;
        OFS_TAG:     strb.rdSel = SEL_TAG;
        OFS_ZBASE0:  strb.rdSel = SEL_ZBASE0;
        OFS_ZBASE1:  strb.rdSel = SEL_ZBASE1;
        OFS_ZCFG:    strb.rdSel = SEL_ZCFG;
        OFS_NBASE0:  strb.rdSel = SEL_NBASE0;
        OFS_NBASE1:  strb.rdSel = SEL_NBASE1;
        OFS_NCFG:    strb.rdSel = SEL_NCFG;
        OFS_PTR0:    strb.rdSel = SEL_PTR0;
        OFS_PTR1:    strb.rdSel = SEL_PTR1;
        default:     strb.rdSel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= isRd;
  end
endmodule

// File: rtl/mmufsr_ptrgen.sv
module mmufsr_ptrgen
  import mmufsr_pkg::*;
(
  input  logic [DATA_W-1:0] tag,
  input  logic [VPN_W-1:0]  zBaseHi,
  input  logic              zSplit,
  input  logic [SIZE_W-1:0] zSize,
  input  logic [PGC_W-1:0]  zPgc,
  input  logic [VPN_W-1:0]  nBaseHi,
  input  logic              nSplit,
  input  logic [SIZE_W-1:0] nSize,
  input  logic [PGC_W-1:0]  nPgc,
  output logic [DATA_W-1:0] ptr
);
  localparam int SH_W = 6;

  logic              useZero;
  logic [VPN_W-1:0]  baseHi;
  logic              split;
  logic [SIZE_W-1:0] size;
  logic [PGC_W-1:0]  pgc;
  logic [SH_W-1:0]   shAmt;
  logic [SH_W-1:0]   topBit;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] idxMask;
  logic [DATA_W-1:0] splitBit;

  assign useZero = (tag[CTX_W-1:0] == '0);
  assign baseHi  = useZero ? zBaseHi : nBaseHi;
  assign split   = useZero ? zSplit  : nSplit;
  assign size    = useZero ? zSize   : nSize;
  assign pgc     = useZero ? zPgc    : nPgc;

  assign shAmt   = SH_W'(9) + SH_W'(3) * SH_W'(pgc);
  assign topBit  = SH_W'(13) + SH_W'(size);
  assign shifted = tag >> shAmt;
  assign idxMask = ((DATA_W'(1) << topBit) - DATA_W'(1)) & ~DATA_W'(16'h000F);
  assign splitBit = split ? (DATA_W'(1) << topBit) : '0;

  assign ptr = {baseHi, {CTX_W{1'b0}}} | splitBit | (shifted & idxMask);
endmodule

// File: rtl/mmufsr_dp.sv
module mmufsr_dp
  import mmufsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] regWData,
  input  logic              faultValid,
  input  logic              faultWrite,
  input  logic [CT_W-1:0]   faultCtxType,
  input  logic              faultSideEffect,
  input  logic [FT_W-1:0]   faultType,
  input  logic [ASI_W-1:0]  faultAsi,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic              tagLoad,
  input  logic [VPN_W-1:0]  tagVpn,
  input  logic [CTX_W-1:0]  tagCtx,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] fsrQ,
  output logic [DATA_W-1:0] farQ,
  output logic [DATA_W-1:0] tagQ
);
  logic [DATA_W-1:0] zeroBase [N_CLASS];
  logic [DATA_W-1:0] nzBase   [N_CLASS];
  logic [DATA_W-1:0] zeroCfg, nzCfg;
  logic [DATA_W-1:0] ptr [N_CLASS];
  logic [DATA_W-1:0] fsrRecord;
  logic [DATA_W-1:0] tagView;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    fsrRecord = '0;
    fsrRecord[1:0] = fsrQ[0] ? 2'b11 : 2'b01;
    fsrRecord[FSR_WR_BIT] = faultWrite;
    fsrRecord[FSR_CT_LSB +: CT_W] = faultCtxType;
    fsrRecord[FSR_SE_BIT] = faultSideEffect;
    fsrRecord[FSR_FT_LSB +: FT_W] = faultType;
    fsrRecord[FSR_ASI_LSB +: ASI_W] = faultAsi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsrQ <= '0;
      farQ <= '0;
      tagQ <= '0;
      zeroCfg <= '0;
      nzCfg <= '0;
    end else begin
      if (faultValid)       fsrQ <= fsrRecord;
      else if (strb.wrFsr)  fsrQ <= regWData;
      if (faultValid)       farQ <= faultAddr;
      if (tagLoad)          tagQ <= {tagVpn, tagCtx};
      else if (strb.wrTag)  tagQ <= regWData;
      if (strb.wrZeroCfg)   zeroCfg <= regWData;
      if (strb.wrNzCfg)     nzCfg <= regWData;
    end
  end

  for (genvar cls = 0; cls < N_CLASS; cls++) begin : g_class
    localparam int PGC_LSB = (cls == 0) ? 0 : 8;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        zeroBase[cls] <= '0;
        nzBase[cls]   <= '0;
      end else begin
        if (strb.wrZeroBase[cls]) zeroBase[cls] <= regWData;
        if (strb.wrNzBase[cls])   nzBase[cls]   <= regWData;
      end
    end

    mmufsr_ptrgen ptr_i (
      .tag     (tagQ),
      .zBaseHi (zeroBase[cls][DATA_W-1:CTX_W]),
      .zSplit  ((cls == 1) && zeroBase[cls][12]),
      .zSize   (zeroBase[cls][SIZE_W-1:0]),
      .zPgc    (zeroCfg[PGC_LSB +: PGC_W]),
      .nBaseHi (nzBase[cls][DATA_W-1:CTX_W]),
      .nSplit  ((cls == 1) && nzBase[cls][12]),
      .nSize   (nzBase[cls][SIZE_W-1:0]),
      .nPgc    (nzCfg[PGC_LSB +: PGC_W]),
      .ptr     (ptr[cls])
    );
  end

  assign tagView = {3'b000, tagQ[CTX_W-1:0], 6'b000000, tagQ[DATA_W-1:22]};

  always_comb begin
    case (strb.rdSel)
      SEL_TAGVIEW: rdMux = tagView;
      SEL_FSR:     rdMux = fsrQ;
      SEL_FAR:     rdMux = farQ;
      SEL_TAG:     rdMux = tagQ;
      SEL_ZBASE0:  rdMux = zeroBase[0];
      SEL_ZBASE1:  rdMux = zeroBase[1];
      SEL_ZCFG:    rdMux = zeroCfg;
      SEL_NBASE0:  rdMux = nzBase[0];
      SEL_NBASE1:  rdMux = nzBase[1];
      SEL_NCFG:    rdMux = nzCfg;
      SEL_PTR0:    rdMux = ptr[0];
      SEL_PTR1:    rdMux = ptr[1];
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdMux;
  end
endmodule

// File: rtl/mmufsr_top.sv
module mmufsr_top
  import mmufsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic              faultWrite,
  input  logic [CT_W-1:0]   faultCtxType,
  input  logic              faultSideEffect,
  input  logic [FT_W-1:0]   faultType,
  input  logic [ASI_W-1:0]  faultAsi,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic              tagLoad,
  input  logic [VPN_W-1:0]  tagVpn,
  input  logic [CTX_W-1:0]  tagCtx,
  input  logic              regReq,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  strobe_t           strb;
  logic [DATA_W-1:0] fsrQ, farQ, tagQ;

  mmufsr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWrite(regWrite),
    .regAddr(regAddr), .strb(strb), .rdValid(rdValid)
  );

  mmufsr_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regWData(regWData),
    .faultValid(faultValid), .faultWrite(faultWrite),
    .faultCtxType(faultCtxType), .faultSideEffect(faultSideEffect),
    .faultType(faultType), .faultAsi(faultAsi), .faultAddr(faultAddr),
    .tagLoad(tagLoad), .tagVpn(tagVpn), .tagCtx(tagCtx),
    .rdData(rdData), .fsrQ(fsrQ), .farQ(farQ), .tagQ(tagQ)
  );
endmodule

// File: rtl/mmufsr_chk.sv
module mmufsr_chk
  import mmufsr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              faultValid,
  input logic [DATA_W-1:0] faultAddr,
  input logic              tagLoad,
  input logic [VPN_W-1:0]  tagVpn,
  input logic [CTX_W-1:0]  tagCtx,
  input logic              regReq,
  input logic              regWrite,
  input logic              rdValid,
  input logic [DATA_W-1:0] fsrQ,
  input logic [DATA_W-1:0] farQ,
  input logic [DATA_W-1:0] tagQ
);
  logic rdReq;
  assign rdReq = regReq && !regWrite;

  a_r2_first_fault: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && !fsrQ[0] |=> fsrQ[1:0] == 2'b01);

  a_r2_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && fsrQ[0] |=> fsrQ[1:0] == 2'b11);

  a_r4_fault_addr: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> farQ == $past(faultAddr));

  a_r5_tag_load: assert property (@(posedge clk) disable iff (!rstN)
    tagLoad |=> tagQ == {$past(tagVpn), $past(tagCtx)});

  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);
endmodule

bind mmufsr_top mmufsr_chk chk_i (
  .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultAddr(faultAddr),
  .tagLoad(tagLoad), .tagVpn(tagVpn), .tagCtx(tagCtx),
  .regReq(regReq), .regWrite(regWrite), .rdValid(rdValid),
  .fsrQ(fsrQ), .farQ(farQ), .tagQ(tagQ)
);

// File: tb/mmufsr_top_tb_top.sv
`timescale 1ns/1ps
module mmufsr_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultValid = 0, faultWrite = 0, faultSideEffect = 0;
  logic [1:0]  faultCtxType = 0;
  logic [6:0]  faultType = 0;
  logic [7:0]  faultAsi = 0;
  logic [63:0] faultAddr = 0;
  logic        tagLoad = 0;
  logic [50:0] tagVpn = 0;
  logic [12:0] tagCtx = 0;
  logic        regReq = 0, regWrite = 0;
  logic [7:0]  regAddr = 0;
  logic [63:0] regWData = 0;
  logic        rdValid;
  logic [63:0] rdData;

  int checks = 0;
  int errors = 0;

  logic [63:0] mFsr = 0, mFar = 0, mTag = 0, mZc = 0, mNc = 0;
  logic [63:0] mZb0 = 0, mZb1 = 0, mNb0 = 0, mNb1 = 0;

  always #5 clk = ~clk;

  mmufsr_top dut_i (.*);

  function automatic logic [63:0] ptrModel(int cls);
    logic [63:0] base, cfg, r;
    int sz, pc, src;
    bit zero;
    zero = (mTag[12:0] == 13'd0);
    if (cls == 0) base = zero ? mZb0 : mNb0;
    else          base = zero ? mZb1 : mNb1;
    cfg = zero ? mZc : mNc;
    sz = int'(base[3:0]);
    pc = (cls == 0) ? int'(cfg[2:0]) : int'(cfg[10:8]);
    r = 64'd0;
    for (int i = 13; i < 64; i++) r[i] = base[i];
    if (cls == 1 && base[12]) r[13 + sz] = 1'b1;
    for (int i = 4; i <= 12 + sz; i++) begin
      src = i + 9 + 3 * pc;
      if (src < 64 && mTag[src]) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [63:0] readModel(logic [7:0] a);
    case (a)
      8'h00: return {3'b0, mTag[12:0], 6'b0, mTag[63:22]};
      8'h18: return mFsr;
      8'h20: return mFar;
      8'h30: return mTag;
      8'h40: return mZb0;
      8'h48: return mZb1;
      8'h50: return mZc;
      8'h58: return mNb0;
      8'h60: return mNb1;
      8'h68: return mNc;
      8'h70: return ptrModel(0);
      8'h78: return ptrModel(1);
      default: return 64'd0;
    endcase
  endfunction

  // one clock: model advance, then compare at next falling edge
  task automatic step(string req);
    logic expV;
    logic [63:0] expD, nf;
    expV = regReq && !regWrite;
    expD = expV ? readModel(regAddr) : 64'd0;
    if (faultValid) begin
      nf = 64'd0;
      nf[1:0] = mFsr[0] ? 2'b11 : 2'b01;
      nf[2] = faultWrite; nf[5:4] = faultCtxType; nf[6] = faultSideEffect;
      nf[13:7] = faultType; nf[23:16] = faultAsi;
      mFsr = nf;
      mFar = faultAddr;
    end else if (regReq && regWrite && regAddr == 8'h18) mFsr = regWData;
    if (tagLoad) mTag = {tagVpn, tagCtx};
    else if (regReq && regWrite && regAddr == 8'h30) mTag = regWData;
    if (regReq && regWrite) begin
      case (regAddr)
        8'h40: mZb0 = regWData;
        8'h48: mZb1 = regWData;
        8'h50: mZc  = regWData;
        8'h58: mNb0 = regWData;
        8'h60: mNb1 = regWData;
        8'h68: mNc  = regWData;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    faultValid = 0; tagLoad = 0; regReq = 0; regWrite = 0;
    checks++;
    if (rdValid !== expV) begin
      errors++;
      $display("FAIL R8 rdValid actual=%0b expected=%0b", rdValid, expV);
    end
    if (expV) begin
      checks++;
      if (rdData !== expD) begin
        errors++;
        $display("FAIL %s offset read data actual=%h expected=%h", req, rdData, expD);
      end
    end
  endtask

  task automatic doRead(logic [7:0] a, string req);
    regReq = 1; regWrite = 0; regAddr = a;
    step(req);
  endtask

  task automatic doWrite(logic [7:0] a, logic [63:0] d, string req);
    regReq = 1; regWrite = 1; regAddr = a; regWData = d;
    step(req);
  endtask

  task automatic setFault(logic w, logic [1:0] ct, logic se, logic [6:0] ft,
                          logic [7:0] asi, logic [63:0] addr);
    faultValid = 1; faultWrite = w; faultCtxType = ct; faultSideEffect = se;
    faultType = ft; faultAsi = asi; faultAddr = addr;
  endtask

  task automatic doTag(logic [50:0] vpn, logic [12:0] ctx, string req);
    tagLoad = 1; tagVpn = vpn; tagCtx = ctx;
    step(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] allOfs [12] = '{8'h00, 8'h18, 8'h20, 8'h30, 8'h40, 8'h48,
                                8'h50, 8'h58, 8'h60, 8'h68, 8'h70, 8'h78};
    int sizes [3] = '{0, 5, 15};
    int codes [3] = '{0, 3, 7};
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (rdValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rdValid in reset actual=%0b expected=0", rdValid);
    end
    rstN = 1;
    step("R1");
    foreach (allOfs[i]) doRead(allOfs[i], "R1");

    // R2/R3/R4: first fault, then overwrite
    setFault(1, 2'd2, 1, 7'd5, 8'h80, 64'hDEAD_BEEF_0000_1234);
    step("R3");
    doRead(8'h18, "R3");
    doRead(8'h20, "R4");
    setFault(0, 2'd1, 0, 7'h7F, 8'h14, 64'h0000_0000_CAFE_0008);
    step("R2");
    doRead(8'h18, "R2");
    doRead(8'h20, "R4");

    // R7: software write, then collision with a fault
    doWrite(8'h18, 64'd0, "R7");
    doRead(8'h18, "R7");
    setFault(0, 2'd3, 1, 7'd1, 8'hFF, 64'h1);
    step("R7");
    doRead(8'h18, "R7");
    setFault(1, 2'd0, 0, 7'd9, 8'h04, 64'h2);
    regReq = 1; regWrite = 1; regAddr = 8'h18; regWData = 64'hFFFF_FFFF_FFFF_FFFE;
    step("R7");
    doRead(8'h18, "R2");
    doWrite(8'h18, 64'h0000_0000_0000_0001, "R7");
    setFault(0, 2'd0, 0, 7'd2, 8'h10, 64'h3);
    step("R2");
    doRead(8'h18, "R2");

    // R5/R6: tag-access load, raw write, collision
    doTag(51'h5_1234_5678_9ABC, 13'h1ABC, "R5");
    doRead(8'h30, "R5");
    doRead(8'h00, "R6");
    doWrite(8'h30, 64'hFEDC_BA98_7654_3210, "R5");
    doRead(8'h30, "R5");
    doRead(8'h00, "R6");
    tagLoad = 1; tagVpn = 51'h3; tagCtx = 13'h5;
    regReq = 1; regWrite = 1; regAddr = 8'h30; regWData = 64'h1111;
    step("R5");
    doRead(8'h30, "R5");

    // R8: read-only and unmapped offsets
    doWrite(8'h20, 64'hAAAA, "R8");
    doRead(8'h20, "R8");
    doWrite(8'h70, 64'hBBBB, "R8");
    doRead(8'h70, "R8");
    doWrite(8'h00, 64'hCCCC, "R8");
    doRead(8'h30, "R8");
    doWrite(8'h08, 64'hDDDD, "R8");
    doRead(8'h08, "R8");
    foreach (allOfs[i]) doRead(allOfs[i], "R8");

    // R9/R10: base selection by context
    doWrite(8'h40, 64'h0000_0040_0000_1003, "R9");
    doWrite(8'h48, 64'h0000_0080_0000_1002, "R9");
    doWrite(8'h50, 64'h0000_0000_0000_0201, "R12");
    doWrite(8'h58, 64'h0000_0100_0000_0001, "R9");
    doWrite(8'h60, 64'h0000_0200_0000_1004, "R9");
    doWrite(8'h68, 64'h0000_0000_0000_0502, "R12");
    doTag(51'h7_FFFF_FFFF_FFFF, 13'h0, "R9");
    doRead(8'h70, "R9");
    doRead(8'h78, "R11");
    doTag(51'h2_4924_9249_2492, 13'h0042, "R9");
    doRead(8'h70, "R10");
    doRead(8'h78, "R11");

    // R10/R11/R12: sweep sizes, page codes, split
    doTag(51'h6_DB6D_B6DB_6DB6, 13'h0001, "R10");
    foreach (sizes[s]) begin
      foreach (codes[c]) begin
        for (int sp = 0; sp < 2; sp++) begin
          doWrite(8'h58, 64'hA5A5_0000_0000_0000 | (64'(sp) << 12) | 64'(sizes[s]), "R10");
          doWrite(8'h60, 64'h5A5A_0000_0000_0000 | (64'(sp) << 12) | 64'(sizes[s]), "R11");
          doWrite(8'h68, (64'(codes[c]) << 8) | 64'((codes[c] + 2) % 8), "R12");
          doRead(8'h70, "R12");
          doRead(8'h78, "R11");
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule